// File: doc/BRIEF.md
# Strobed Parallel Port Expander

This block is a slave on a narrow parallel bus that a host drives with plain I/O lines and no clock. The host places a location number on a 3-bit address, chooses a direction with a read select line, and frames each transfer with an active-low cycle strobe. Data travels over one shared 8-bit bus. The pad for that bus is split here into an input, an output and an output enable.

The block holds eight output registers that drive an external output port. It also offers eight external input bytes that the host can read back. Reads and writes have separate address spaces, so location 2 for a write is a different thing from location 2 for a read. Every bus line passes through a two-flop synchroniser before use. A small state machine moves through the states ST_IDLE, ST_READ, ST_WRITE and ST_COMMIT.

The state machine has the following transitions:
- From ST_IDLE, a detected falling strobe edge (a "launch") goes to ST_READ when the read select is high, and to ST_WRITE when it is low.
- From ST_READ, a high strobe returns to ST_IDLE.
- From ST_WRITE, a high strobe goes to ST_COMMIT.
- From ST_COMMIT, the machine returns to ST_IDLE. If a new launch is detected in that same cycle, it goes straight to ST_READ or ST_WRITE instead.

Top module: `strobe_io_expander`

## Requirements
- R1: While reset is asserted and just after it, every output register reads zero and `host_dq_oe` is low.
- R2: A write transfer (`host_rd` = 0) stores the bus byte into output register `host_addr`, which drives `out_port[8*k+7:8*k]` for k = `host_addr`. No other register changes.
- R3: An output register does not change while the strobe is still low. It updates only after the host returns the strobe high.
- R4: The byte that is committed is the last value present on `host_dq_i` while the strobe was low. A change of data during the low phase therefore replaces the earlier value.
- R5: A read transfer (`host_rd` = 1) drives `in_port[8*k+7:8*k]` for k = `host_addr` onto `host_dq_o`, with `host_dq_oe` high, from the third clock edge after the strobe falls.
- R6: The read byte is captured when the strobe falls. Changes on `in_port` later in the same transfer do not alter `host_dq_o`.
- R7: Changes to `host_addr` or `host_rd` while the strobe is low are ignored for the transfer in progress.
- R8: Read and write spaces are separate. A read returns the input port byte and never a written value, and it leaves every output register unchanged.
- R9: `host_dq_oe` is high only during a read transfer. It is still high at the second clock edge after the strobe rises and is low from the third.
- R10: A strobe that is already low when reset is released starts no transfer. Only a high-to-low strobe edge seen after reset begins one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Location number from the host |
| host_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| host_cyc_n | input | 1 | Active-low cycle strobe framing a transfer |
| host_dq_i | input | 8 | Data bus as seen at the pad |
| host_dq_o | output | 8 | Data the block drives during a read |
| host_dq_oe | output | 1 | Pad output enable for the data bus |
| out_port | output | 64 | Eight output register bytes, byte k in bits 8k+7..8k |
| in_port | input | 64 | Eight external input bytes, byte k in bits 8k+7..8k |

## Verification
The bench builds the block with its default parameters: an address width of 3, a data width of 8 and two synchroniser stages. At that size both address spaces hold only eight locations, so every write location and every read location is visited in two sweeps, each with an arithmetic data pattern. This brings the independence of the two spaces and of each register within direct reach. Directed transfers cover the remaining cases: data, address, select and input changes in the middle of a transfer, the exact edge on which the bus is released, and a strobe held low through reset.

// File: rtl/pio_xp_pkg.sv
package pio_xp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_COMMIT = 2'd3
    } xfer_state_t;

endpackage

// File: rtl/pio_xp_sync.sv
module pio_xp_sync #(
    parameter int            W        = 1,
    parameter int            STAGES   = 2,
    parameter logic [W-1:0]  RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pio_xp_fsm.sv
module pio_xp_fsm
    import pio_xp_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_n_s,
    input  logic          rd_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          rd_load,
    output logic [AW-1:0] sel_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          bus_oe
);

    xfer_state_t state, state_nx;
    logic        cyc_prev;
    logic        fall;
    logic        launch;

    // Edge detector; reset value 0 so a strobe low at reset release is no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_prev <= 1'b0;
        else        cyc_prev <= cyc_n_s;
    end

    assign fall   = cyc_prev & ~cyc_n_s;
    assign launch = fall & ((state == ST_IDLE) | (state == ST_COMMIT));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (launch) state_nx = rd_s ? ST_READ : ST_WRITE;
            end
            ST_READ: begin
                if (cyc_n_s) state_nx = ST_IDLE;
            end
            ST_WRITE: begin
                if (cyc_n_s) state_nx = ST_COMMIT;
            end
            ST_COMMIT: begin
                if (launch) state_nx = rd_s ? ST_READ : ST_WRITE;
                else        state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_oe  = 1'b0;
        wr_en   = 1'b0;
        rd_load = 1'b0;
        unique case (state)
            ST_IDLE:   rd_load = launch & rd_s;
            ST_READ:   bus_oe  = 1'b1;
            ST_WRITE:  ;
            ST_COMMIT: begin
                wr_en   = 1'b1;
                rd_load = launch & rd_s;
            end
            default:   ;
        endcase
    end

    // Address captured once per transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_addr <= '0;
        else if (launch) sel_addr <= addr_s;
    end

    // Write data: last value seen while strobe low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wr_data <= '0;
        else if (launch && !rd_s)
            wr_data <= data_s;
        else if (state == ST_WRITE && !cyc_n_s)
            wr_data <= data_s;
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && ($past(state) == ST_READ || $past(state) == ST_WRITE))
        |-> $stable(sel_addr)); // R7

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R2

    AST_OE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !$past(cyc_n_s)); // R9

endmodule

// File: rtl/pio_xp_in_sample.sv
module pio_xp_in_sample #(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [AW-1:0]            addr,
    input  logic [(1<<AW)*DW-1:0]    in_s,
    output logic [DW-1:0]            rd_hold
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] bytes [NREG];

    genvar k;
    generate
        for (k = 0; k < NREG; k++) begin : g_split
            assign bytes[k] = in_s[k*DW +: DW];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rd_hold <= '0;
        else if (load) rd_hold <= bytes[addr];
    end

    AST_SNAPSHOT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rd_hold)); // R6

endmodule

// File: rtl/pio_xp_out_bank.sv
module pio_xp_out_bank #(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            data,
    output logic [(1<<AW)*DW-1:0]    regs
);

    localparam int NREG = 1 << AW;

    genvar k;
    generate
        for (k = 0; k < NREG; k++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[k*DW +: DW] <= '0;
                else if (wr_en && addr == AW'(k))
                    regs[k*DW +: DW] <= data;
            end
        end
    endgenerate

    AST_REG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs)); // R3

endmodule

// File: rtl/strobe_io_expander.sv
module strobe_io_expander #(
    parameter int AW          = 3,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           host_addr,
    input  logic                    host_rd,
    input  logic                    host_cyc_n,
    input  logic [DW-1:0]           host_dq_i,
    output logic [DW-1:0]           host_dq_o,
    output logic                    host_dq_oe,
    output logic [(1<<AW)*DW-1:0]   out_port,
    input  logic [(1<<AW)*DW-1:0]   in_port
);

    localparam int NREG = 1 << AW;
    localparam int CW   = DW + AW + 2;
    localparam int PW   = NREG * DW;

    logic [CW-1:0]  ctrl_s;
    logic           cyc_n_s;
    logic           rd_s;
    logic [AW-1:0]  addr_s;
    logic [DW-1:0]  data_s;
    logic [PW-1:0]  in_s;

    logic           rd_load;
    logic [AW-1:0]  sel_addr;
    logic           wr_en;
    logic [DW-1:0]  wr_data;
    logic           bus_oe;

    // Host bus lines; all reset to 0 so a low strobe at release is no edge
    pio_xp_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_cyc_n, host_rd, host_addr, host_dq_i}),
        .q     (ctrl_s)
    );

    assign {cyc_n_s, rd_s, addr_s, data_s} = ctrl_s;

    pio_xp_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_in (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (in_port),
        .q     (in_s)
    );

    pio_xp_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_n_s  (cyc_n_s),
        .rd_s     (rd_s),
        .addr_s   (addr_s),
        .data_s   (data_s),
        .rd_load  (rd_load),
        .sel_addr (sel_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .bus_oe   (bus_oe)
    );

    pio_xp_in_sample #(.AW(AW), .DW(DW)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rd_load),
        .addr    (addr_s),
        .in_s    (in_s),
        .rd_hold (host_dq_o)
    );

    pio_xp_out_bank #(.AW(AW), .DW(DW)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (sel_addr),
        .data  (wr_data),
        .regs  (out_port)
    );

    assign host_dq_oe = bus_oe;

    AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !host_dq_oe); // R8

endmodule

// File: tb/strobe_io_expander_bench.sv
module strobe_io_expander_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_cyc_n = 1'b1;
    logic [7:0]  host_dq_i = '0;
    logic [7:0]  host_dq_o;
    logic        host_dq_oe;
    logic [63:0] out_port;
    logic [63:0] in_port = '0;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [7:0]  mdl [8];

    always #4 clk = ~clk;

    strobe_io_expander u_strobe_io_expander (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_rd    (host_rd),
        .host_cyc_n (host_cyc_n),
        .host_dq_i  (host_dq_i),
        .host_dq_o  (host_dq_o),
        .host_dq_oe (host_dq_oe),
        .out_port   (out_port),
        .in_port    (in_port)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = mdl[k];
        return r;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_rd = 1'b0; host_dq_i = d;
        step(2);
        host_cyc_n = 1'b0;
        step(8);
        chk("R3 no update while strobe low", out_port, model_flat());
        host_cyc_n = 1'b1;
        mdl[a] = d;
        step(8);
        chk("R2 write commits to addressed byte only", out_port, model_flat());
    endtask

    task automatic host_read(input logic [2:0] a);
        logic [7:0] exp;
        exp = in_port[a*8 +: 8];
        host_addr = a; host_rd = 1'b1;
        step(2);
        host_cyc_n = 1'b0;
        step(8);
        chk("R5 read data", {56'd0, host_dq_o}, {56'd0, exp});
        chk("R5 read oe", {63'd0, host_dq_oe}, 64'd1);
        host_cyc_n = 1'b1;
        step(2);
        chk("R9 oe held to second edge", {63'd0, host_dq_oe}, 64'd1);
        step(1);
        chk("R9 oe released at third edge", {63'd0, host_dq_oe}, 64'd0);
        step(5);
        chk("R8 read leaves outputs", out_port, model_flat());
    endtask

    task automatic set_inputs(input bit inv);
        for (int k = 0; k < 8; k++) begin
            logic [7:0] v;
            v = 8'((k * 29 + 7) & 255);
            in_port[k*8 +: 8] = inv ? ~v : v;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired, run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) mdl[k] = 8'h00;
        // R10 setup: strobe held low with a write pending through reset
        host_cyc_n = 1'b0; host_rd = 1'b0; host_addr = 3'd3; host_dq_i = 8'hAA;
        step(4);
        chk("R1 outputs zero in reset", out_port, 64'd0);
        chk("R1 oe low in reset", {63'd0, host_dq_oe}, 64'd0);
        rst_n = 1'b1;
        step(1);
        chk("R1 outputs zero after reset", out_port, 64'd0);
        step(5);
        host_cyc_n = 1'b1;
        step(8);
        chk("R10 low strobe at reset release ignored", out_port, 64'd0);
        chk("R10 no bus drive", {63'd0, host_dq_oe}, 64'd0);

        // Sweep 1: all write locations ascending, then all read locations
        set_inputs(1'b0);
        for (int a = 0; a < 8; a++) host_write(3'(a), 8'((a * 53 + 11) & 255));
        for (int a = 0; a < 8; a++) host_read(3'(a));

        // Sweep 2: descending writes, inverted inputs
        set_inputs(1'b1);
        for (int a = 7; a >= 0; a--) host_write(3'(a), 8'(a * 17) ^ 8'hC3);
        for (int a = 7; a >= 0; a--) host_read(3'(a));

        // R6 / R7: read with mid-transfer changes of input, address, select
        host_addr = 3'd2; host_rd = 1'b1;
        step(2);
        host_cyc_n = 1'b0;
        step(8);
        chk("R5 read before disturbance", {56'd0, host_dq_o}, {56'd0, in_port[23:16]});
        begin
            logic [7:0] held;
            held = in_port[23:16];
            in_port[23:16] = ~held;
            host_addr = 3'd5; host_rd = 1'b0; host_dq_i = 8'h5A;
            step(8);
            chk("R6 input change mid-read ignored", {56'd0, host_dq_o}, {56'd0, held});
            chk("R7 addr/select change mid-read ignored", {63'd0, host_dq_oe}, 64'd1);
        end
        host_cyc_n = 1'b1;
        step(8);
        chk("R7 select flip did not write", out_port, model_flat());

        // R4 / R7: write with mid-transfer data and address change
        host_addr = 3'd4; host_rd = 1'b0; host_dq_i = 8'h11;
        step(2);
        host_cyc_n = 1'b0;
        step(8);
        host_dq_i = 8'hE7; host_addr = 3'd6; host_rd = 1'b1;
        step(8);
        chk("R3 write pending, outputs unchanged", out_port, model_flat());
        chk("R7 select flip mid-write gives no drive", {63'd0, host_dq_oe}, 64'd0);
        host_cyc_n = 1'b1;
        mdl[4] = 8'hE7;
        step(8);
        chk("R4 last low-phase data committed, R7 address held", out_port, model_flat());

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule